// File: doc/BRIEF.md
# Loadable Up Counter with Carry Chain

This block is a synchronous binary up counter of configurable width with a parallel load path and a carry-in/carry-out pair for building wider counters out of narrow ones. On each rising clock edge the register takes one of three next values: the parallel data word, its own value plus one, or its own value unchanged. The next value is settled combinationally while the clock is low and captured on the rising edge. Both the count and its bitwise complement are driven out.

The choice of next value is an operation code with three named values, re-decided every cycle from the inputs: OP_LOAD (load high; highest priority), OP_COUNT (load low, enable and carry-in both high), and OP_HOLD (every other case). Any operation may follow any other in the next cycle; there is no stored control state apart from the count itself. A synchronous active-high reset overrides all three and clears the count. Bits are numbered from 0 at the most significant end, so the least significant bit is index WIDTH-1 and an increment ripples from that index toward index 0. To cascade, the carry-out of the lower counter drives the carry-in of the upper one and both share the enable. A width below 2 stops elaboration.

Top module: `loadable_up_counter`

## Requirements
- R1: When rst is high at a rising clock edge, count_q is all zeros after that edge, whatever load, count_en and carry_in are.
- R2: When rst is low and load is high at a rising edge, count_q equals data_in after that edge, even if count_en and carry_in are both high.
- R3: When rst and load are low and count_en and carry_in are both high at a rising edge, count_q becomes its previous value plus one, modulo 2^WIDTH.
- R4: When rst and load are low and count_en or carry_in is low at a rising edge, count_q keeps its value.
- R5: An increment from all ones gives all zeros.
- R6: carry_out is high exactly when carry_in is high and every bit of count_q is one; it follows carry_in with no clock delay.
- R7: count_n is always the bitwise complement of count_q.
- R8: Index WIDTH-1 of count_q and data_in is the least significant bit and index 0 the most significant: one increment from zero sets only count_q[WIDTH-1].
- R9: Two instances, the upper one taking the lower one's carry_out as carry_in and both sharing count_en, count together as one counter of twice the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; capture on rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load | input | 1 | Parallel load strobe, wins over counting |
| count_en | input | 1 | Count enable |
| carry_in | input | 1 | Carry from a lower stage; also gates counting |
| data_in | input | WIDTH | Parallel load word, index WIDTH-1 is the LSB |
| count_q | output | WIDTH | Registered count, index WIDTH-1 is the LSB |
| count_n | output | WIDTH | Bitwise complement of count_q |
| carry_out | output | 1 | carry_in AND all bits of count_q |

## Verification
The assertions watch every edge for the clear after reset, the load priority, the plus-one step with its wrap, the hold when either gating input is low, and the carry-out relation to the count. The complement output, the bit order of the count and the behaviour of two cascaded instances are shown only by the bench, through directed loads near all ones and a long random run compared against a bench model.

// File: rtl/luc_pkg.sv
package luc_pkg;

    // Per-cycle operation chosen for the next register value
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } luc_op_e;

endpackage

// File: rtl/luc_mode_sel.sv
module luc_mode_sel
    import luc_pkg::*;
(
    input  logic    load,
    input  logic    count_en,
    input  logic    carry_in,
    output luc_op_e op
);

    always_comb begin
        if (load) begin
            op = OP_LOAD;
        end else if (count_en && carry_in) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/luc_incr.sv
module luc_incr #(
    parameter int WIDTH = 8
) (
    input  logic [0:WIDTH-1] a,
    output logic [0:WIDTH-1] sum
);

    // carry[i] is the carry entering bit i-1; carry[WIDTH] is the +1 injected at the LSB
    logic [1:WIDTH] carry;

    assign carry[WIDTH] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_sum
            assign sum[gi] = a[gi] ^ carry[gi+1];
        end
        for (gi = 1; gi < WIDTH; gi++) begin : g_carry
            assign carry[gi] = a[gi] & carry[gi+1];
        end
    endgenerate

endmodule

// File: rtl/luc_carry.sv
module luc_carry #(
    parameter int WIDTH = 8
) (
    input  logic [0:WIDTH-1] value,
    input  logic             cin,
    output logic             cout
);

    // Propagate chain from the LSB end (index WIDTH-1) toward index 0
    logic [0:WIDTH] prop;

    assign prop[WIDTH] = cin;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_prop
            assign prop[gi] = prop[gi+1] & value[gi];
        end
    endgenerate

    assign cout = prop[0];

endmodule

// File: rtl/loadable_up_counter.sv
module loadable_up_counter
    import luc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             count_en,
    input  logic             carry_in,
    input  logic [0:WIDTH-1] data_in,
    output logic [0:WIDTH-1] count_q,
    output logic [0:WIDTH-1] count_n,
    output logic             carry_out
);

    generate
        if (WIDTH < 2) begin : g_width_check
            $error("loadable_up_counter: WIDTH must be at least 2");
        end
    endgenerate

    luc_op_e          op;
    logic [0:WIDTH-1] state_q;
    logic [0:WIDTH-1] state_d;
    logic [0:WIDTH-1] plus_one;

    luc_mode_sel u_mode (
        .load     (load),
        .count_en (count_en),
        .carry_in (carry_in),
        .op       (op)
    );

    luc_incr #(.WIDTH(WIDTH)) u_incr (
        .a   (state_q),
        .sum (plus_one)
    );

    luc_carry #(.WIDTH(WIDTH)) u_carry (
        .value (state_q),
        .cin   (carry_in),
        .cout  (carry_out)
    );

    // Next value, settled while the clock is low
    always_comb begin
        unique case (op)
            OP_LOAD:  state_d = data_in;
            OP_COUNT: state_d = plus_one;
            OP_HOLD:  state_d = state_q;
            default:  state_d = state_q;
        endcase
    end

    // State register, captured on the rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        count_q = state_q;
        count_n = ~state_q;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count_q == '0)); // R1

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load)) |-> (count_q == $past(data_in))); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !load && count_en && carry_in)
        |-> (count_q == WIDTH'($past(count_q) + 1'b1))); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !load && !(count_en && carry_in)) |-> $stable(count_q)); // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !load && count_en && carry_in && (&count_q))
        |-> (count_q == '0)); // R5

    AST_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
        carry_out == (carry_in && ($countones(count_q) == WIDTH))); // R6

endmodule

// File: tb/loadable_up_counter_tb.sv
`timescale 1ns/1ps
module loadable_up_counter_tb;

    localparam int W  = 8;
    localparam int CW = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst = 1'b1;
    logic         load = 1'b0, count_en = 1'b0, carry_in = 1'b0;
    logic [0:W-1] data_in = '0;
    logic [0:W-1] count_q, count_n;
    logic         carry_out;

    loadable_up_counter #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .load(load), .count_en(count_en),
        .carry_in(carry_in), .data_in(data_in), .count_q(count_q),
        .count_n(count_n), .carry_out(carry_out)
    );

    // Cascade pair
    logic          c_load = 1'b0, c_en = 1'b0;
    logic [0:CW-1] lo_d = '0, hi_d = '0;
    logic [0:CW-1] lo_q, hi_q, lo_n, hi_n;
    logic          lo_co, hi_co;

    loadable_up_counter #(.WIDTH(CW)) u_lo (
        .clk(clk), .rst(rst), .load(c_load), .count_en(c_en),
        .carry_in(1'b1), .data_in(lo_d), .count_q(lo_q),
        .count_n(lo_n), .carry_out(lo_co)
    );

    loadable_up_counter #(.WIDTH(CW)) u_hi (
        .clk(clk), .rst(rst), .load(c_load), .count_en(c_en),
        .carry_in(lo_co), .data_in(hi_d), .count_q(hi_q),
        .count_n(hi_n), .carry_out(hi_co)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [W-1:0] m;
    logic [2*CW-1:0] cm;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_next(input logic l, input logic e, input logic c,
                                                input logic [W-1:0] cur, input logic [W-1:0] d);
        if (l) return d;
        if (e && c) return cur + 1'b1;
        return cur;
    endfunction

    // Called at a falling edge; checks outputs one falling edge later
    task automatic step(input logic l, input logic e, input logic c,
                        input logic [W-1:0] d, input string req);
        load = l; count_en = e; carry_in = c; data_in = d;
        #1;
        chk("R6", {31'b0, carry_out}, {31'b0, c & (m == '1)});
        chk("R7", {24'b0, 8'(count_n)}, {24'b0, 8'(~count_q)});
        m = model_next(l, e, c, m, d);
        @(negedge clk);
        chk(req, {24'b0, 8'(count_q)}, {24'b0, m});
    endtask

    task automatic cstep(input logic l, input logic e, input logic [2*CW-1:0] d);
        c_load = l; c_en = e; {hi_d, lo_d} = d;
        if (l) cm = d; else if (e) cm = cm + 1'b1;
        @(negedge clk);
        chk("R9", {24'b0, 4'(hi_q), 4'(lo_q)}, {24'b0, cm});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4321));
        m = '0;
        cm = '0;
        repeat (2) @(negedge clk);
        chk("R1", {24'b0, 8'(count_q)}, 32'h0);
        chk("R1", {24'b0, 4'(hi_q), 4'(lo_q)}, 32'h0);
        rst = 1'b0;

        // R8: one increment from zero sets only the highest index
        step(1'b0, 1'b1, 1'b1, 8'h00, "R3");
        chk("R8", {31'b0, count_q[W-1]}, 32'h1);
        chk("R8", {31'b0, count_q[0]}, 32'h0);
        // R8: data_in index 0 is the MSB
        step(1'b1, 1'b0, 1'b0, 8'h80, "R2");
        data_in = '0; data_in[0] = 1'b1;
        step(1'b1, 1'b0, 1'b0, data_in, "R8");

        // R2: load wins over counting
        step(1'b1, 1'b1, 1'b1, 8'hFE, "R2");
        // R4: hold when one gate is low
        step(1'b0, 1'b1, 1'b0, 8'h00, "R4");
        step(1'b0, 1'b0, 1'b1, 8'h33, "R4");
        // R6: carry_out at all ones
        step(1'b0, 1'b1, 1'b1, 8'h00, "R3");
        step(1'b0, 1'b0, 1'b0, 8'h00, "R4");
        step(1'b0, 1'b0, 1'b1, 8'h00, "R4");
        // R5: wrap to zero
        step(1'b0, 1'b1, 1'b1, 8'h00, "R5");

        // R1: reset beats load mid-run
        step(1'b1, 1'b0, 1'b0, 8'h5A, "R2");
        rst = 1'b1; load = 1'b1; count_en = 1'b1; carry_in = 1'b1; data_in = 8'hC3;
        @(negedge clk);
        chk("R1", {24'b0, 8'(count_q)}, 32'h0);
        rst = 1'b0;
        m = '0;
        cm = '0;

        // Random run
        for (int i = 0; i < 400; i++) begin
            logic rl, re, rc;
            logic [W-1:0] rd;
            rl = ($urandom % 8) == 0;
            re = ($urandom % 4) != 0;
            rc = ($urandom % 4) != 0;
            rd = W'($urandom);
            if (($urandom % 16) == 0) rd = 8'hFF;
            step(rl, re, rc, rd, rl ? "R2" : ((re && rc) ? "R3" : "R4"));
        end

        // R9: cascade through the carry pair
        cstep(1'b1, 1'b0, 8'hFD);
        for (int i = 0; i < 5; i++) cstep(1'b0, 1'b1, 8'h00);
        cstep(1'b0, 1'b0, 8'h00);
        cstep(1'b1, 1'b1, 8'h0E);
        for (int i = 0; i < 40; i++) cstep(1'b0, ($urandom % 3) != 0, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule